// File: doc/BRIEF.md
# Rolling Key Register with S-box Refresh

This block holds the 16-byte key of a byte-serial stream cipher and hands one key byte to the datapath on every sub-round. A pointer picks the active byte, and each sub-round advance moves the pointer forward by three positions, wrapping modulo 16. The datapath around the block (state bytes, accumulator, keystream selection) consumes the active byte and is not part of this block.

The key does not stay fixed while the cipher runs. On every seventh advance after a load, the two bytes just above the active pointer are rewritten. Each becomes the substitution-box image of its old value XORed with the active byte. The active byte keeps its value because the next sub-round still reads it. Both replacements are computed combinationally from the registered key and written on the same edge that moves the pointer, so the next key byte is ready with no idle cycle.

A parallel load writes all sixteen bytes at once. It also returns the pointer to its start position and clears the refresh cadence. The substitution box is the standard byte substitution of the well-known 128-bit block cipher. The block computes it from field arithmetic rather than reading it from a stored table.

Top module: `rolling_key_reg`

## Requirements
- R1: After reset, `key_ptr` is 0 and `key_byte` is 0, because every stored byte resets to 0x00.
- R2: A cycle with `key_load` high stores byte i from `key_in[8*i+7:8*i]` for every i in 0..15, sets `key_ptr` to 0 and clears the refresh count. From the next cycle, `key_byte` shows byte 0.
- R3: A cycle with `step_en` high and `key_load` low sets `key_ptr` to (`key_ptr` + 3) mod 16.
- R4: `key_byte` always equals the stored byte addressed by `key_ptr`.
- R5: Counting accepted advances (`step_en` high, `key_load` low) from the last load or reset, advances number 7, 14, 21 and so on are refresh advances. On a refresh advance with pointer p, byte (p+1) mod 16 becomes S(old[(p+1) mod 16] XOR old[p]) and byte (p+2) mod 16 becomes S(old[(p+2) mod 16] XOR old[p]). Both use the values held before the edge.
- R6: On a refresh advance, byte p and the other thirteen bytes keep their values. On any other advance, no byte changes.
- R7: When `key_load` and `step_en` are both high in the same cycle, the load wins: the pointer goes to 0, the new key is stored and no advance takes place.
- R8: S is the byte substitution of the standard 128-bit block cipher. It takes the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapped to 0. It then applies the affine map b XOR rotl(b,1) XOR rotl(b,2) XOR rotl(b,3) XOR rotl(b,4) XOR 0x63. So S(0x00)=0x63.
- R9: A cycle with both `key_load` and `step_en` low leaves the pointer, the key bytes and the refresh count unchanged.
- R10: The refresh indices wrap modulo 16. A refresh at pointer 14 rewrites bytes 15 and 0, and a refresh at pointer 15 rewrites bytes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Parallel key load strobe |
| key_in | input | 128 | Key bytes, byte i in bits 8*i+7..8*i |
| step_en | input | 1 | Sub-round advance strobe |
| key_byte | output | 8 | Stored key byte at the pointer |
| key_ptr | output | 4 | Current active-byte pointer |

## Verification
The bench runs long advance streams of more than seventy sub-rounds, so that refreshes land on every pointer phase. This includes the two wrapping cases at pointers 14 and 15, where an unreduced index would write outside the array or into the wrong byte. Idle cycles are scattered through the streams. A counter that advanced on idle cycles would then refresh on the wrong sub-round, and every byte read afterwards would diverge from the model. From an all-zero key, the first refresh must produce 0x63 in byte 4 and leave byte 5 at zero. A design that computed the box wrongly, or that overwrote the active byte, fails those two reads. A load asserted together with an advance must restart at pointer 0 with the new key. A design that gave the advance priority would show pointer 3.

// File: rtl/rk_pkg.sv
package rk_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Multiply in GF(2^8) reduced by x^8+x^4+x^3+x+1 (shift and add).
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = sh[7] ? ((sh << 1) ^ 8'h1b) : (sh << 1);
        end
        return acc;
    endfunction

    // x^254 gives the inverse (and maps 0 to 0), then the affine map.
    function automatic byte_t sbox_fwd(input byte_t x);
        byte_t sq;
        byte_t inv;
        byte_t res;
        sq  = x;
        inv = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        for (int i = 0; i < BYTE_W; i++) begin
            res[i] = inv[i] ^ inv[(i + 4) % BYTE_W] ^ inv[(i + 5) % BYTE_W]
                   ^ inv[(i + 6) % BYTE_W] ^ inv[(i + 7) % BYTE_W];
        end
        return res ^ 8'h63;
    endfunction

endpackage

// File: rtl/rk_sbox.sv
module rk_sbox
    import rk_pkg::*;
(
    input  byte_t in_byte,
    output byte_t out_byte
);

    always_comb begin
        out_byte = sbox_fwd(in_byte);
    end

endmodule

// File: rtl/rk_ptr_ctrl.sv
module rk_ptr_ctrl #(
    parameter int NBYTES   = 16,
    parameter int STEP     = 3,
    parameter int PERIOD   = 7,
    parameter int PTR_INIT = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      step,
    output logic [$clog2(NBYTES)-1:0] p_act,
    output logic [$clog2(NBYTES)-1:0] p_nx1,
    output logic [$clog2(NBYTES)-1:0] p_nx2,
    output logic                      refresh
);

    localparam int PW = $clog2(NBYTES);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] PINIT = PW'(PTR_INIT);
    localparam logic [CW-1:0] CLAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_q, st_d;
    logic  fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        if (load) begin
            st_d.ptr = PINIT;
            st_d.cnt = '0;
        end else if (step) begin
            st_d.ptr = PW'((int'(st_q.ptr) + STEP) % NBYTES);
            if (st_q.cnt == CLAST) begin
                fire_d   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= PINIT;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        p_act   = st_q.ptr;
        p_nx1   = PW'((int'(st_q.ptr) + 1) % NBYTES);
        p_nx2   = PW'((int'(st_q.ptr) + 2) % NBYTES);
        refresh = fire_d;
    end

endmodule

// File: rtl/rk_key_bank.sv
module rk_key_bank
    import rk_pkg::*;
#(
    parameter int NBYTES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NBYTES*BYTE_W-1:0]    load_bytes,
    input  logic                        refresh,
    input  logic [$clog2(NBYTES)-1:0]   p_act,
    input  logic [$clog2(NBYTES)-1:0]   p_nx1,
    input  logic [$clog2(NBYTES)-1:0]   p_nx2,
    output byte_t                       act_byte,
    output logic [NBYTES*BYTE_W-1:0]    bank_flat
);

    typedef struct packed {
        logic [NBYTES-1:0][BYTE_W-1:0] bytes;
    } bank_t;

    bank_t bank_q, bank_d;
    byte_t rd_act, rd_nx1, rd_nx2;
    byte_t new_nx1, new_nx2;
    logic [NBYTES-1:0] wen_nx1, wen_nx2;
    logic [NBYTES-1:0][BYTE_W-1:0] byte_d;

    // Three byte-wide read multiplexers.
    always_comb begin
        rd_act = bank_q.bytes[p_act];
        rd_nx1 = bank_q.bytes[p_nx1];
        rd_nx2 = bank_q.bytes[p_nx2];
    end

    rk_sbox i_sbox_nx1 (.in_byte(rd_nx1 ^ rd_act), .out_byte(new_nx1));
    rk_sbox i_sbox_nx2 (.in_byte(rd_nx2 ^ rd_act), .out_byte(new_nx2));

    // Per-byte one-hot write enables and next values.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign wen_nx1[g] = refresh && (int'(p_nx1) == g);
        assign wen_nx2[g] = refresh && (int'(p_nx2) == g);
        always_comb begin
            if (load)
                byte_d[g] = load_bytes[g*BYTE_W +: BYTE_W];
            else if (wen_nx1[g])
                byte_d[g] = new_nx1;
            else if (wen_nx2[g])
                byte_d[g] = new_nx2;
            else
                byte_d[g] = bank_q.bytes[g];
        end
    end

    always_comb begin
        bank_d.bytes = byte_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.bytes <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign act_byte  = rd_act;
    assign bank_flat = bank_q.bytes;

endmodule

// File: rtl/rolling_key_reg.sv
module rolling_key_reg
    import rk_pkg::*;
#(
    parameter int NBYTES   = 16,
    parameter int STEP     = 3,
    parameter int PERIOD   = 7,
    parameter int PTR_INIT = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        key_load,
    input  logic [NBYTES*BYTE_W-1:0]    key_in,
    input  logic                        step_en,
    output logic [BYTE_W-1:0]           key_byte,
    output logic [$clog2(NBYTES)-1:0]   key_ptr
);

    localparam int PW = $clog2(NBYTES);

    logic [PW-1:0]              p_act, p_nx1, p_nx2;
    logic                       refresh;
    logic [NBYTES*BYTE_W-1:0]   bank_flat;
    byte_t                      act_byte;

    rk_ptr_ctrl #(
        .NBYTES(NBYTES), .STEP(STEP), .PERIOD(PERIOD), .PTR_INIT(PTR_INIT)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .load(key_load), .step(step_en),
        .p_act(p_act), .p_nx1(p_nx1), .p_nx2(p_nx2), .refresh(refresh)
    );

    rk_key_bank #(.NBYTES(NBYTES)) i_bank (
        .clk(clk), .rst_n(rst_n), .load(key_load), .load_bytes(key_in),
        .refresh(refresh), .p_act(p_act), .p_nx1(p_nx1), .p_nx2(p_nx2),
        .act_byte(act_byte), .bank_flat(bank_flat)
    );

    assign key_byte = act_byte;
    assign key_ptr  = p_act;

endmodule

// File: rtl/rk_checker.sv
module rk_checker #(
    parameter int NBYTES   = 16,
    parameter int STEP     = 3,
    parameter int PERIOD   = 7,
    parameter int PTR_INIT = 0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      key_load,
    input logic [NBYTES*8-1:0]       key_in,
    input logic                      step_en,
    input logic [7:0]                key_byte,
    input logic [$clog2(NBYTES)-1:0] key_ptr,
    input logic [NBYTES*8-1:0]       bank_flat,
    input logic                      refresh
);

    localparam int PW = $clog2(NBYTES);

    logic [PW-1:0] ptr_prev;
    logic [7:0]    kb_prev;
    int            adv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_prev <= '0;
            kb_prev  <= '0;
            adv_cnt  <= 0;
        end else begin
            ptr_prev <= key_ptr;
            kb_prev  <= key_byte;
            if (key_load)
                adv_cnt <= 0;
            else if (step_en)
                adv_cnt <= (adv_cnt == PERIOD - 1) ? 0 : adv_cnt + 1;
        end
    end

    // R2
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> (key_ptr == PW'(PTR_INIT))
                  && (key_byte == $past(key_in[PTR_INIT*8 +: 8])));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !key_load) |=>
            key_ptr == PW'((int'($past(key_ptr)) + STEP) % NBYTES));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !key_load) |=> $stable(key_ptr) && $stable(bank_flat));

    // R6
    plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !key_load && !refresh) |=> $stable(bank_flat));

    // R6
    active_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> bank_flat[ptr_prev*8 +: 8] == kb_prev);

    // R5
    cadence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh == (step_en && !key_load && adv_cnt == PERIOD - 1));

endmodule

bind rolling_key_reg rk_checker #(
    .NBYTES(NBYTES), .STEP(STEP), .PERIOD(PERIOD), .PTR_INIT(PTR_INIT)
) u_rk_checker (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .step_en(step_en), .key_byte(key_byte), .key_ptr(key_ptr),
    .bank_flat(bank_flat), .refresh(refresh)
);

// File: tb/test_rolling_key_reg.sv
module test_rolling_key_reg;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         step_en = 1'b0;
    logic [7:0]   key_byte;
    logic [3:0]   key_ptr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string key_tag = "R4";

    int sb [256];
    int mk [16];
    int mp = 0;
    int mc = 0;

    always #10 clk = ~clk;

    rolling_key_reg i_rolling_key_reg (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .step_en(step_en), .key_byte(key_byte), .key_ptr(key_ptr)
    );

    function automatic int mulp(int a, int b);
        int r = 0;
        while (b != 0) begin
            if (b & 1) r ^= a;
            a = a << 1;
            if (a & 256) a ^= 'h11b;
            b = b >> 1;
        end
        return r;
    endfunction

    function automatic int rotl8(int v, int n);
        return ((v << n) | (v >> (8 - n))) & 255;
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            int inv = 0;
            for (int y = 1; y < 256; y++)
                if (x != 0 && mulp(x, y) == 1) inv = y;
            sb[x] = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                  ^ rotl8(inv, 4) ^ 'h63;
        end
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            summary();
            $finish;
        end
    end

    // Compare outputs, drive the next inputs and advance the model.
    task automatic cyc(logic ld, logic adv, logic [127:0] kv);
        @(negedge clk);
        check("R3", key_ptr, mp);
        check(key_tag, key_byte, mk[mp]);
        key_load = ld;
        step_en  = adv;
        key_in   = kv;
        if (ld) begin
            for (int i = 0; i < 16; i++) mk[i] = kv[i*8 +: 8];
            mp = 0;
            mc = 0;
        end else if (adv) begin
            if (mc == 6) begin
                int a = mk[mp];
                int i1 = (mp + 1) % 16;
                int i2 = (mp + 2) % 16;
                mk[i1] = sb[mk[i1] ^ a];
                mk[i2] = sb[mk[i2] ^ a];
                mc = 0;
            end else begin
                mc++;
            end
            mp = (mp + 3) % 16;
        end
    endtask

    function automatic logic [127:0] mk_key(int seed);
        logic [127:0] k;
        for (int i = 0; i < 16; i++) k[i*8 +: 8] = 8'((i * 37 + seed * 11 + 5) & 255);
        return k;
    endfunction

    initial begin
        build_sbox();
        check("R8", sb[0], 'h63);
        check("R8", sb['h53], 'hed);
        for (int i = 0; i < 16; i++) mk[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", key_ptr, 0);
        check("R1", key_byte, 0);
        rst_n = 1'b1;

        // R2: load and read back byte 0
        cyc(1, 0, mk_key(1));
        cyc(0, 0, '0);
        check("R2", key_byte, 5 + 11);
        check("R2", key_ptr, 0);

        // R3 R4 R5 R9: long stream with idle gaps
        key_tag = "R5";
        for (int n = 0; n < 200; n++) cyc(0, (n % 9) != 4, '0);

        // R6 R8: zero key, first refresh rewrites bytes 3 and 4
        key_tag = "R6";
        cyc(1, 0, '0);
        for (int n = 0; n < 7; n++) cyc(0, 1, '0);
        cyc(0, 0, '0);
        check("R6", key_ptr, 5);
        check("R6", key_byte, 0);
        for (int n = 0; n < 5; n++) cyc(0, 1, '0);
        cyc(0, 0, '0);
        check("R8", key_ptr, 4);
        check("R8", key_byte, 'h63);

        // R7: load together with advance
        cyc(1, 1, mk_key(2));
        cyc(0, 0, '0);
        check("R7", key_ptr, 0);
        check("R7", key_byte, (2 * 11 + 5) & 255);

        // R10: refreshes at pointers 14 and 15 (wrapping indices)
        key_tag = "R10";
        cyc(1, 0, mk_key(3));
        for (int n = 0; n < 120; n++) cyc(0, 1, '0);
        for (int n = 0; n < 4; n++) cyc(0, 0, '0);
        // R9: idle leaves pointer where the model has it
        check("R9", key_ptr, mp);

        summary();
        $finish;
    end

endmodule